// File: doc/BRIEF.md
# LIN Responder Frame Handler

This block handles the byte-level flow of a LIN frame on the responding side of the bus. It sits behind a UART receiver and transmitter and sees only whole bytes and a break strobe. Once a break is reported, it expects the sync byte and then reads the protected identifier. The identifier selects one of two paths. On the listen path the node takes in a fixed number of payload bytes and a checksum. On the respond path it sends its own stored bytes, followed by a checksum that it computes.

The checksum is the bitwise inverse of an 8-bit sum with end-around carry. The sum covers the identifier and every payload byte. A correctly checked listen frame, or a fully sent response, produces a one-cycle done pulse. A checksum that does not match produces a one-cycle error pulse. In both cases the handler returns to idle and raises its break-arm output again, so the UART can look for the next break.

Top module: `lin_resp_frame`

## Requirements
- R1: A cycle with `brk_det` high, in any state, sends the handler to wait for the sync byte. `brk_arm` is low from the next cycle until the frame ends.
- R2: If the first byte after a break is not 0x55, the handler returns to idle. `brk_arm` goes high again and neither `frame_done` nor `frame_err` pulses.
- R3: An identifier byte of 0xAD starts a listen frame. The next three received bytes are written to `rx_payload`, first byte in bits [7:0]. The fourth byte is the checksum.
- R4: An identifier byte of 0x3C starts a respond frame. The handler offers `resp_bytes[7:0]`, then `resp_bytes[15:8]`, then the checksum on `tx_data`. Each byte is held with `tx_valid` high until a cycle with `tx_ready` high.
- R5: Any other identifier value returns the handler to idle without flags and without any transmission.
- R6: After the last byte of a frame, the handler is idle with `brk_arm` high.
- R7: The checksum is the inverse of the end-around-carry sum of the identifier and the data bytes. For identifier 0xAD with data 0x01, 0x02, 0x03 the checksum is 0x4C.
- R8: A received checksum that matches pulses `frame_done` for one cycle. A checksum that does not match pulses `frame_err` for one cycle instead. The two never pulse together.
- R9: A break in the middle of a frame drops that frame without flags, and the next bytes are taken as sync, identifier and data.
- R10: Received bytes are ignored in idle and while a response is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| brk_det | input | 1 | Break detected strobe |
| brk_arm | output | 1 | High while break detection should be enabled (idle) |
| resp_bytes | input | 8*TX_LEN | Response payload, byte 0 in the low bits |
| tx_valid | output | 1 | Byte offered for transmission |
| tx_data | output | 8 | Byte to transmit |
| tx_ready | input | 1 | Transmitter accepts the offered byte |
| rx_payload | output | 8*RX_LEN | Payload of the listen frame |
| frame_done | output | 1 | One-cycle pulse when a frame completes correctly |
| frame_err | output | 1 | One-cycle pulse on a checksum mismatch |

## Verification
The bench builds the block with its default parameters: three listen bytes, two response bytes, and the identifiers 0xAD and 0x3C. These values make the known 0xAD/0x01/0x02/0x03 checksum of 0x4C checkable directly. With all-0xFF payloads and responses, the same values also force the end-around carry on every addition. The transmitter's ready signal is stalled on alternate cycles during one response, so the hold of each offered byte is exercised.

// File: rtl/lin_resp_frame.sv
module lin_resp_frame #(
  parameter int          RX_LEN      = 3,
  parameter int          TX_LEN      = 2,
  parameter logic [7:0]  SYNC_BYTE   = 8'h55,
  parameter logic [7:0]  LISTEN_PID  = 8'hAD,
  parameter logic [7:0]  RESPOND_PID = 8'h3C
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rx_valid,
  input  logic [7:0]          rx_data,
  input  logic                brk_det,
  output logic                brk_arm,
  input  logic [8*TX_LEN-1:0] resp_bytes,
  output logic                tx_valid,
  output logic [7:0]          tx_data,
  input  logic                tx_ready,
  output logic [8*RX_LEN-1:0] rx_payload,
  output logic                frame_done,
  output logic                frame_err
);
  localparam int MAXLEN = (RX_LEN > TX_LEN) ? RX_LEN : TX_LEN;
  localparam int CNT_W  = $clog2(MAXLEN + 1);

  typedef enum logic [2:0] {S_IDLE, S_SYNC, S_PID, S_RXD, S_TXD} state_t;

  state_t           state;
  logic [CNT_W-1:0] cnt;
  logic [7:0]       acc;
  logic [7:0]       resp_byte;

  function automatic logic [7:0] eac_add(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[7:0] + {7'd0, s[8]};
  endfunction

  always_comb begin
    resp_byte = 8'h00;
    for (int i = 0; i < TX_LEN; i++)
      if (cnt == CNT_W'(i)) resp_byte = resp_bytes[8*i +: 8];
  end

  assign brk_arm  = (state == S_IDLE);
  assign tx_valid = (state == S_TXD);
  assign tx_data  = (cnt == CNT_W'(TX_LEN)) ? ~acc : resp_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      cnt        <= '0;
      acc        <= '0;
      rx_payload <= '0;
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      frame_err  <= 1'b0;
      if (brk_det) begin
        state <= S_SYNC;
        cnt   <= '0;
      end else begin
        case (state)
          S_SYNC: if (rx_valid) state <= (rx_data == SYNC_BYTE) ? S_PID : S_IDLE;
          S_PID: if (rx_valid) begin
            acc <= rx_data;
            cnt <= '0;
            if (rx_data == LISTEN_PID)       state <= S_RXD;
            else if (rx_data == RESPOND_PID) state <= S_TXD;
            else                             state <= S_IDLE;
          end
          S_RXD: if (rx_valid) begin
            if (cnt == CNT_W'(RX_LEN)) begin
              if (rx_data == ~acc) frame_done <= 1'b1;
              else                 frame_err  <= 1'b1;
              state <= S_IDLE;
            end else begin
              acc <= eac_add(acc, rx_data);
              for (int i = 0; i < RX_LEN; i++)
                if (cnt == CNT_W'(i)) rx_payload[8*i +: 8] <= rx_data;
              cnt <= cnt + 1'b1;
            end
          end
          S_TXD: if (tx_ready) begin
            if (cnt == CNT_W'(TX_LEN)) begin
              frame_done <= 1'b1;
              state      <= S_IDLE;
            end else begin
              acc <= eac_add(acc, resp_byte);
              cnt <= cnt + 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

module lin_resp_frame_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       brk_det,
  input logic       brk_arm,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       frame_done,
  input logic       frame_err
);
  a_r1_break_disarms: assert property (@(posedge clk) disable iff (!rst_n)
    brk_det |=> !brk_arm);
  a_r6_done_rearms: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done || frame_err) |-> brk_arm);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(frame_done && frame_err));
  a_r4_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !brk_det) |=> (tx_valid && $stable(tx_data)));
  a_r5_no_tx_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !brk_arm);
endmodule

bind lin_resp_frame lin_resp_frame_chk u_chk (.*);

// File: tb/lin_resp_frame_test.sv
module lin_resp_frame_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        rx_valid = 0;
  logic [7:0]  rx_data = 0;
  logic        brk_det = 0;
  logic        brk_arm;
  logic [15:0] resp_bytes = 16'h0201;
  logic        tx_valid;
  logic [7:0]  tx_data;
  logic        tx_ready = 1;
  logic [23:0] rx_payload;
  logic        frame_done, frame_err;

  int checks = 0, failures = 0;
  bit stall = 0;
  bit finished = 0;
  logic [7:0] exp_q[$];

  always #5 clk = ~clk;

  lin_resp_frame uut (.*);

  always @(posedge clk) tx_ready <= stall ? ~tx_ready : 1'b1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && tx_valid && tx_ready) begin
    if (exp_q.size() == 0) chk("R4 unexpected tx", {24'd0, tx_data}, 32'hxx);
    else chk("R4 tx byte", {24'd0, tx_data}, {24'd0, exp_q.pop_front()});
  end

  task automatic send_brk();
    @(negedge clk) brk_det = 1;
    @(negedge clk) brk_det = 0;
    chk("R1 brk_arm low after break", {31'd0, brk_arm}, 0);
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk) begin rx_valid = 1; rx_data = b; end
    @(negedge clk) rx_valid = 0;
  endtask

  task automatic listen(input logic [7:0] d0, d1, d2, ck, input bit good, input string req);
    send_byte(8'h55); send_byte(8'hAD);
    send_byte(d0); send_byte(d1); send_byte(d2);
    @(negedge clk) begin rx_valid = 1; rx_data = ck; end
    @(negedge clk) rx_valid = 0;
    chk({req, " done"}, {31'd0, frame_done}, {31'd0, good});
    chk({req, " err"}, {31'd0, frame_err}, {31'd0, !good});
    chk("R6 rearmed", {31'd0, brk_arm}, 1);
    chk("R3 payload", {8'd0, rx_payload}, {8'd0, d2, d1, d0});
  endtask

  task automatic respond(input logic [15:0] r, input logic [7:0] ck);
    int n;
    resp_bytes = r;
    exp_q.push_back(r[7:0]); exp_q.push_back(r[15:8]); exp_q.push_back(ck);
    send_brk(); send_byte(8'h55); send_byte(8'h3C);
    send_byte(8'hAA);  // R10: ignored during response
    n = 0;
    while ((exp_q.size() != 0 || tx_valid) && n < 50) begin @(negedge clk); n++; end
    chk("R4 queue drained", exp_q.size(), 0);
    chk("R6 rearmed after tx", {31'd0, brk_arm}, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset brk_arm", {31'd0, brk_arm}, 1);
    chk("reset tx_valid", {31'd0, tx_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    // R7 known checksum, R3 listen, R8 done
    send_brk(); listen(8'h01, 8'h02, 8'h03, 8'h4C, 1, "R7 example");
    // R7 carry path
    send_brk(); listen(8'hFF, 8'hFF, 8'hFF, 8'h52, 1, "R7 carry");
    // R8 mismatch
    send_brk(); listen(8'h01, 8'h02, 8'h03, 8'h4D, 0, "R8 mismatch");
    // R2 bad sync
    send_brk(); send_byte(8'h54);
    chk("R2 bad sync idle", {31'd0, brk_arm}, 1);
    // R10 bytes in idle ignored
    send_byte(8'hAD); send_byte(8'h09); send_byte(8'h09); send_byte(8'h09);
    send_byte(8'h40);
    chk("R10 idle no done", {30'd0, frame_done, frame_err}, 0);
    chk("R10 idle payload kept", {8'd0, rx_payload}, 32'h00030201);
    // R5 unknown pid
    send_brk(); send_byte(8'h55); send_byte(8'h12);
    chk("R5 unknown pid idle", {31'd0, brk_arm}, 1);
    repeat (3) @(negedge clk);
    chk("R5 no tx", {31'd0, tx_valid}, 0);
    // R9 mid-frame break
    send_brk(); send_byte(8'h55); send_byte(8'hAD); send_byte(8'h07);
    send_brk();
    chk("R9 no flag on abort", {30'd0, frame_done, frame_err}, 0);
    listen(8'h01, 8'h02, 8'h03, 8'h4C, 1, "R9 restart");
    // R4 respond
    respond(16'h0201, 8'hC0);
    stall = 1;
    respond(16'hFFFF, 8'hC3);
    stall = 0;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule